// File: doc/BRIEF.md
# Hybrid Sparse/Dense Prefix Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns their sum together with a carry-out. The carry computation is a parallel-prefix network. It is built to use fewer prefix operators than a classic Han-Carlson tree while keeping logarithmic depth.

Each bit first produces a generate (both operand bits set) and a propagate (operand bits differ). The carry-in is folded into the generate of bit 0. The prefix network then runs in four phases:

- two sparse reduction levels, which build spans of two on the odd bits and spans of four on bits with index 3 mod 4;
- a dense doubling network that runs only on the 3-mod-4 bits, at distances 4 up to half the width;
- a sparse fill-in level at distance 2, which completes the remaining odd bits;
- a final fill-in level at distance 1, which completes the even bits.

Fill-in cells produce only a group generate. Each sum bit is its propagate XORed with the completed carry into it.

The block has no clock, no reset and no state, so there are no states or transitions to name. It settles within one combinational path of log2(N)+2 prefix levels, plus the pre- and post-processing gates. It is meant to sit inside a datapath stage that registers its inputs and outputs.

Top module: `hhc_adder`

## Requirements
- R1: For any operands and carry-in, the concatenation {carry_out, sum} equals opa + opb + carry_in, computed at WIDTH+1 bits.
- R2: The carry-in adds weight one at bit 0 only. With both operands zero and carry_in = 1, sum = 1 and carry_out = 0.
- R3: When opb is the bitwise inverse of opa, every bit propagates. With carry_in = 1 the result is sum = 0 and carry_out = 1. With carry_in = 0 the result is sum = all ones and carry_out = 0.
- R4: A carry generated at a single bit k travels through all higher propagating bits. With opa = 2^k and opb = 2^WIDTH - 2^k, the result is sum = 0 and carry_out = 1, for every k.
- R5: When the operands share no set bit and carry_in = 0, sum = opa | opb and carry_out = 0.
- R6: Both operands all ones with carry_in = 1 gives sum = all ones and carry_out = 1.
- R7: After the last prefix level, the group generate at every bit i equals the carry out of bits i..0 including the carry-in. The sum bit at i+1 depends on it, and for the top bit it is carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum of the operands and carry-in, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench targets these corner cases:

- **Full-length propagate chains**, where the carry-in or a generate at a single bit has to pass through every later level. A missing or misplaced cell in the dense or fill-in phases would leave a sum bit at one instead of zero.
- **Carry-in on zero operands.** A fold at the wrong bit would shift the carry-in or lose it.
- **Disjoint operands.** A spurious generate would corrupt them.
- **Alternating patterns and random vectors.** These exercise mixed group spans, where a cell wired at the wrong distance gives a wrong sum at isolated bit positions.

// File: rtl/hhc_pkg.sv
package hhc_pkg;

    // Distance to the lower partner of bit i at prefix level lv, 0 when the bit passes through.
    function automatic int lvl_dist(int lv, int i, int log2w);
        int d;
        d = 0;
        if (lv == 1) begin
            if (i % 2 == 1) d = 1;
        end else if (lv == 2) begin
            if (i % 4 == 3) d = 2;
        end else if (lv <= log2w) begin
            if ((i % 4 == 3) && (i >= (1 << (lv - 1)))) d = 1 << (lv - 1);
        end else if (lv == log2w + 1) begin
            if ((i % 4 == 1) && (i >= 4)) d = 2;
        end else begin
            if ((i % 2 == 0) && (i >= 2)) d = 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/hhc_pregen.sv
module hhc_pregen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);

    always_comb begin
        prop = opa ^ opb;
        gen  = opa & opb;
        gen[0] = (opa[0] & opb[0]) | (prop[0] & carry_in);
    end

    logic [1:0] lsb_total;
    always_comb begin
        lsb_total = {1'b0, opa[0]} + {1'b0, opb[0]} + {1'b0, carry_in};
        // R2: folded generate of bit 0 equals the arithmetic carry of bit 0 with carry-in
        a_r2_fold: assert (gen[0] == lsb_total[1])
            else $error("bit 0 fold mismatch");
    end

endmodule

// File: rtl/hhc_prefix_tree.sv
module hhc_prefix_tree #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] grp
);

    localparam int LOG2 = $clog2(WIDTH);
    localparam int NLVL = LOG2 + 2;

    logic [WIDTH-1:0] g_l [0:NLVL];
    logic [WIDTH-1:0] p_l [0:NLVL];

    assign g_l[0] = gen;
    assign p_l[0] = prop;

    for (genvar lv = 1; lv <= NLVL; lv++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam int D = hhc_pkg::lvl_dist(lv, i, LOG2);
            if (D > 0) begin : g_cell
                assign g_l[lv][i] = g_l[lv-1][i] | (p_l[lv-1][i] & g_l[lv-1][i-D]);
                if (lv <= LOG2) begin : g_black
                    assign p_l[lv][i] = p_l[lv-1][i] & p_l[lv-1][i-D];
                end else begin : g_grey
                    assign p_l[lv][i] = p_l[lv-1][i];
                end
            end else begin : g_pass
                assign g_l[lv][i] = g_l[lv-1][i];
                assign p_l[lv][i] = p_l[lv-1][i];
            end
        end
    end

    assign grp = g_l[NLVL];

    logic rip;
    always_comb begin
        rip = gen[0];
        for (int i = 0; i < WIDTH; i++) begin
            if (i > 0) rip = gen[i] | (prop[i] & rip);
            // R7: each completed group generate matches a serial carry reference
            a_r7_group_gen: assert (grp[i] == rip)
                else $error("group generate mismatch at bit %0d", i);
        end
    end

endmodule

// File: rtl/hhc_sumgen.sv
module hhc_sumgen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] grp,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    always_comb begin
        sum       = prop ^ {grp[WIDTH-2:0], carry_in};
        carry_out = grp[WIDTH-1];
    end

endmodule

// File: rtl/hhc_adder.sv
module hhc_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] grp;

    hhc_pregen #(.WIDTH(WIDTH)) i_pregen (
        .opa(opa), .opb(opb), .carry_in(carry_in), .gen(gen), .prop(prop)
    );

    hhc_prefix_tree #(.WIDTH(WIDTH)) i_tree (
        .gen(gen), .prop(prop), .grp(grp)
    );

    hhc_sumgen #(.WIDTH(WIDTH)) i_sumgen (
        .prop(prop), .grp(grp), .carry_in(carry_in), .sum(sum), .carry_out(carry_out)
    );

    logic [WIDTH:0] ref_total;
    always_comb begin
        ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
        // R1: full result equals arithmetic sum
        a_r1_total: assert ({carry_out, sum} == ref_total)
            else $error("sum mismatch");
        // R3: inverse operands propagate carry-in through every bit
        if (opb == ~opa) begin
            a_r3_full_chain: assert ((carry_out == carry_in) && (sum == {WIDTH{~carry_in}}))
                else $error("propagate chain mismatch");
        end
    end

endmodule

// File: tb/test_hhc_adder.sv
`timescale 1ns/1ps
module test_hhc_adder;

    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum;
    logic         carry_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    hhc_adder #(.WIDTH(W)) i_hhc_adder (
        .opa(opa), .opb(opb), .carry_in(carry_in), .sum(sum), .carry_out(carry_out)
    );

    function automatic logic [W:0] model(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y, logic c,
                         logic [W:0] expv);
        @(posedge clk);
        opa = x; opb = y; carry_in = c;
        @(negedge clk);
        checks++;
        if ({carry_out, sum} !== expv) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
                     req, x, y, c, {carry_out, sum}, expv);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic c;
        void'($urandom(32'h5eed_1234));
        // R1 idle inputs
        apply("R1 zero", '0, '0, 1'b0, '0);
        // R2 carry-in alone
        apply("R2 cin only", '0, '0, 1'b1, 33'd1);
        // R3 full propagate chains
        apply("R3 chain cin1", 32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1, {1'b1, 32'h0});
        apply("R3 chain cin0", 32'h1234_5678, ~32'h1234_5678, 1'b0, {1'b0, 32'hFFFF_FFFF});
        apply("R3 all ones plus one", 32'hFFFF_FFFF, '0, 1'b1, {1'b1, 32'h0});
        apply("R3 all ones plus b one", 32'hFFFF_FFFF, 32'h1, 1'b0, {1'b1, 32'h0});
        // R4 single generate at each bit
        for (int k = 0; k < W; k++) begin
            x = 32'h1 << k;
            y = 32'hFFFF_FFFF << k;
            apply("R4 generate walk", x, y, 1'b0, {1'b1, 32'h0});
        end
        // R5 disjoint operands
        apply("R5 alternating", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, {1'b0, 32'hFFFF_FFFF});
        apply("R5 nibbles", 32'hF0F0_0F0F, 32'h0F0F_0000, 1'b0, {1'b0, 32'hFFFF_0F0F});
        // R6 maximum operands
        apply("R6 max max cin", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'hFFFF_FFFF});
        // R1 alternating patterns added to themselves
        apply("R1 alt self", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, model(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1));
        apply("R1 alt self 5", 32'h5555_5555, 32'h5555_5555, 1'b0, model(32'h5555_5555, 32'h5555_5555, 1'b0));
        // R7 carry into every bit position via partial propagate runs
        for (int k = 1; k < W; k++) begin
            x = (32'h1 << k) - 1;
            apply("R7 run", x, '0, 1'b1, model(x, '0, 1'b1));
        end
        // R1 random vectors
        for (int n = 0; n < 2000; n++) begin
            x = $urandom;
            y = $urandom;
            c = 1'($urandom);
            apply("R1 random", x, y, c, model(x, y, c));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule